// File: doc/BRIEF.md
# Serial Reclocker Lock Qualifier

This block decides when a serial reclocker may call itself locked and gates the retimed data accordingly. It receives the retimed bit stream, one bit per clock, along with the phase detector's lock flag. It raises its lock output only when three things are true: the stream is toggling, the loop is phase locked, and the loop is not sitting on a harmonic of the true rate.

Presence of data is judged by a short window. Too many consecutive bits equal to their predecessor means the input has gone quiet. A brief stall shorter than the window is tolerated without any effect on the output. Harmonic lock shows up as every bit cell being sampled twice, so a lone bit that differs from both its neighbours can never appear. A longer window therefore requires at least one such isolated bit. Each window is a counter that restarts on its event and saturates at its limit.

While lock is low the data output freezes at the last value it passed. The clock-output enable is a plain function of the enable input and ignores lock state.

Top module: `lkq_lock_qual`

## Requirements
- R1: During and directly after reset, lock_o is 0 and tx_bit_o is 0. Both history bits reset to 0, both window counters reset to their limits, and the registered phase flag resets to 0.
- R2: When ACT_WIN consecutive sampled bits each equal the bit sampled one clock earlier, lock_o is 0 in the cycle after the last of them.
- R3: A run of at most ACT_WIN-1 sampled bits equal to their predecessor leaves lock_o high and the data passing.
- R4: A bit is isolated when it differs from both the bit before it and the bit after it, i.e. the last three samples are 101 or 010. lock_o is 0 once HARM_WIN consecutive samples have passed with no isolated pattern completed, so doubled data (pairs 0011...) drops lock.
- R5: lock_o is 1 only if pll_lock_i was 1 at the previous clock edge. A single low sample drops lock_o one cycle later.
- R6: While lock_o is 0, tx_bit_o holds its value unchanged.
- R7: While lock_o is 1 at a clock edge, tx_bit_o after that edge equals rx_bit_i sampled at that edge.
- R8: clk_oe_o equals clk_en_i at all times, whatever the lock state.
- R9: After reset, lock_o stays 0 with pll_lock_i high and transitions present until an isolated pattern has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one retimed bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Retimed serial bit |
| pll_lock_i | input | 1 | Phase lock flag from the loop |
| clk_en_i | input | 1 | Serial clock output enable request |
| tx_bit_o | output | 1 | Serial data out, frozen while unlocked |
| lock_o | output | 1 | Qualified lock indication |
| clk_oe_o | output | 1 | Serial clock output enable |

## Verification
An activity counter that is off by one shows at lock_o exactly at the run-length boundary, so runs of ACT_WIN and ACT_WIN+1 equal bits are driven back to back. A fault in the bit history creates or hides isolated patterns, but this only becomes visible once a full harmonic window has elapsed. Doubled data is therefore held for longer than HARM_WIN, both right after reset and after lock. A wrong mute register shows on tx_bit_o one cycle after lock changes, and it is compared on every cycle against a model built from the requirements.

// File: rtl/lkq_pkg.sv
package lkq_pkg;
  // bits needed for a counter that saturates at lim
  function automatic int unsigned cnt_w(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/lkq_bit_hist.sv
module lkq_bit_hist (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic edge_o,
  output logic iso_o
);
  // hist_q[0] previous bit, hist_q[1] the one before
  logic [1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 2'b00;
    else         hist_q <= {hist_q[0], data_i};
  end

  assign edge_o = data_i ^ hist_q[0];
  assign iso_o  = (hist_q[1] ^ hist_q[0]) & (hist_q[0] ^ data_i);
endmodule

// File: rtl/lkq_win_timer.sv
module lkq_win_timer #(
  parameter int unsigned WIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic live_o
);
  localparam int unsigned CW = lkq_pkg::cnt_w(WIN);
  localparam logic [CW-1:0] LIM = CW'(WIN);

  logic [CW-1:0] cnt_q;

  // counts samples since last hit; starts expired
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= LIM;
    else if (hit_i)        cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign live_o = (cnt_q != LIM);
endmodule

// File: rtl/lkq_mute.sv
module lkq_mute (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic data_i,
  output logic data_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= 1'b0;
    else if (lock_i) hold_q <= data_i;
  end

  assign data_o = hold_q;
endmodule

// File: rtl/lkq_lock_qual.sv
module lkq_lock_qual #(
  parameter int unsigned ACT_WIN  = 8,
  parameter int unsigned HARM_WIN = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic pll_lock_i,
  input  logic clk_en_i,
  output logic tx_bit_o,
  output logic lock_o,
  output logic clk_oe_o
);
  logic edge_ev, iso_ev;
  logic act_live, harm_live;
  logic pll_q;

  lkq_bit_hist hist_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (rx_bit_i),
    .edge_o (edge_ev),
    .iso_o  (iso_ev)
  );

  lkq_win_timer #(.WIN(ACT_WIN)) act_tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (edge_ev),
    .live_o (act_live)
  );

  lkq_win_timer #(.WIN(HARM_WIN)) harm_tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (iso_ev),
    .live_o (harm_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pll_q <= 1'b0;
    else         pll_q <= pll_lock_i;
  end

  // AND of registered terms only
  assign lock_o = act_live & harm_live & pll_q;

  lkq_mute mute_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock_o),
    .data_i (rx_bit_i),
    .data_o (tx_bit_o)
  );

  assign clk_oe_o = clk_en_i;
endmodule

// File: rtl/lkq_lock_qual_chk.sv
module lkq_lock_qual_chk #(
  parameter int unsigned ACT_WIN = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_bit_i,
  input logic pll_lock_i,
  input logic tx_bit_o,
  input logic lock_o
);
  logic        prev_q;
  int unsigned idle_q;

  // independent run-length count of unchanged bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      idle_q <= 0;
    end else begin
      prev_q <= rx_bit_i;
      if (rx_bit_i != prev_q) idle_q <= 0;
      else if (idle_q < ACT_WIN) idle_q <= idle_q + 1;
    end
  end

  // R2
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q >= ACT_WIN) |-> !lock_o);

  // R5
  pll_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> $past(pll_lock_i));

  // R6
  mute_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |=> $stable(tx_bit_o));

  // R7
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> (tx_bit_o == $past(rx_bit_i)));
endmodule

bind lkq_lock_qual lkq_lock_qual_chk #(.ACT_WIN(ACT_WIN)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_bit_i   (rx_bit_i),
  .pll_lock_i (pll_lock_i),
  .tx_bit_o   (tx_bit_o),
  .lock_o     (lock_o)
);

// File: tb/lkq_lock_qual_tb.sv
module lkq_lock_qual_tb_top;
  localparam int CLK_P = 10;
  localparam int ACT  = 8;
  localparam int HARM = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_bit = 1'b0, pll_lock = 1'b0, clk_en = 1'b0;
  logic tx_bit, lock, clk_oe;

  always #(CLK_P/2) clk = ~clk;

  lkq_lock_qual #(.ACT_WIN(ACT), .HARM_WIN(HARM)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_bit_i(rx_bit), .pll_lock_i(pll_lock),
    .clk_en_i(clk_en), .tx_bit_o(tx_bit), .lock_o(lock), .clk_oe_o(clk_oe)
  );

  typedef struct {
    logic  lk;
    logic  dat;
    logic  oe;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // model state, from the requirements
  int   m_act = ACT, m_harm = HARM;
  logic m_lock = 0, m_data = 0, m_p1 = 0, m_p2 = 0, m_pll = 0;
  logic [6:0] lfsr = 7'h5A;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic p, input logic ce);
    exp_t e;
    bit ev, iso;
    @(negedge clk);
    rx_bit = b; pll_lock = p; clk_en = ce;
    ev  = (b != m_p1);
    iso = (m_p2 != m_p1) && (m_p1 != b);
    if (m_lock) m_data = b;
    m_act  = ev  ? 0 : ((m_act  < ACT)  ? m_act + 1  : ACT);
    m_harm = iso ? 0 : ((m_harm < HARM) ? m_harm + 1 : HARM);
    m_pll  = p;
    m_lock = (m_act < ACT) && (m_harm < HARM) && m_pll;
    m_p2 = m_p1; m_p1 = b;
    e.lk = m_lock; e.dat = m_data; e.oe = ce; e.tag = cur_req;
    sb_q.push_back(e);
  endtask

  task automatic rnd_bits(input int n, input logic p);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      step(lfsr[0], p, lfsr[3]);
    end
  endtask

  task automatic dbl_bits(input int pairs, input logic p);
    for (int i = 0; i < pairs; i++) begin
      step(i[0], p, 1'b1);
      step(i[0], p, 1'b1);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  // monitor: pops one expected item after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(lock,   e.lk,  e.tag, "lock_o");
        chk(tx_bit, e.dat, (e.tag == "R7") ? "R7" : "R6", "tx_bit_o");
        chk(clk_oe, e.oe,  "R8", "clk_oe_o");
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lock, 1'b0, "R1", "lock_o in reset");
    chk(tx_bit, 1'b0, "R1", "tx_bit_o in reset");
    rst_ni = 1'b1;
    settle();
    chk(lock, 1'b0, "R1", "lock_o after reset");
    chk(tx_bit, 1'b0, "R1", "tx_bit_o after reset");

    cur_req = "R9";
    dbl_bits(30, 1'b1);
    settle();
    chk(lock, 1'b0, "R9", "no isolated bit yet");

    cur_req = "R7";
    rnd_bits(80, 1'b1);
    settle();
    chk(lock, 1'b1, "R7", "locked on live data");

    cur_req = "R3";
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < ACT; i++) step(1'b1, 1'b1, 1'b0);
    settle();
    chk(lock, 1'b1, "R3", "short stall kept");
    step(1'b0, 1'b1, 1'b1);

    cur_req = "R2";
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < ACT + 1; i++) step(1'b0, 1'b1, 1'b1);
    settle();
    chk(lock, 1'b0, "R2", "stall dropped lock");

    cur_req = "R5";
    rnd_bits(20, 1'b0);
    settle();
    chk(lock, 1'b0, "R5", "pll low keeps unlocked");

    cur_req = "R7";
    rnd_bits(60, 1'b1);
    settle();
    chk(lock, 1'b1, "R7", "relock");

    cur_req = "R5";
    step(1'b1, 1'b0, 1'b1);
    settle();
    chk(lock, 1'b0, "R5", "single pll drop");
    rnd_bits(10, 1'b1);
    settle();
    chk(lock, 1'b1, "R5", "recovered after pll drop");

    cur_req = "R4";
    dbl_bits(30, 1'b1);
    settle();
    chk(lock, 1'b0, "R4", "harmonic lock rejected");

    cur_req = "R8";
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    settle();
    settle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule